// File: doc/BRIEF.md
# DMA Physical Channel Allocator

This block hands out physical DMA channels to logical peripheral request lines. Sixteen physical channels are grouped into two banks of eight. Each request names a logical peripheral ID, and the ID range decides which bank may serve it. The lowest-numbered free channel in that bank is taken. The channel is then marked busy and tagged with the requesting ID. A logical-to-physical map entry for the ID is written so that later lookups and releases can find the channel.

A grant is returned as a handle: the physical channel number with a flag bit raised, so that software can tell a hardware channel handle apart from a logical ID. A channel can be freed in two ways. It can be freed by handle, which leaves the map untouched. It can also be freed by logical ID, which frees whatever channel the map holds for that ID and then clears the entry. Two read ports give registered views of the tables: one maps a logical ID to its channel, the other maps a channel to its occupancy and owner.

Top module: `dma_chan_alloc`

## Requirements
- R1: After reset no channel is busy, no map entry is valid and `rsp_valid` is 0. `req_ready` and `rel_ready` are 1 from the first cycle after reset is removed.
- R2: Logical IDs 0 to 15 are granted only channels 0 to 7. IDs 16 to 31 are granted only channels 8 to 15.
- R3: Within the selected bank, the grant goes to the lowest-indexed channel that is not busy.
- R4: If every channel of the selected bank is busy, the response has `rsp_busy`=1 and `rsp_handle`=0. Neither the occupancy, the owner table nor the map changes.
- R5: A successful handle has bit 28 set and the channel number in bits 3:0. All other bits are 0.
- R6: A grant records the requesting ID as the channel's owner. One cycle after `own_chan` is presented, `own_busy` and `own_id` show that channel's state, and `own_id` is 0 for a free channel.
- R7: A grant sets the map entry of the requesting ID to the granted channel. One cycle after `lkp_id` is presented, `lkp_valid`=1 and `lkp_chan` hold it.
- R8: A release key with bit 28 set, a channel number in bits 3:0 and every other bit 0 frees that channel and leaves the map as it was. A key with bit 28 set and any other bit above 3 set is ignored.
- R9: A release key with bit 28 clear and a value below 32 is a logical ID. It frees the channel mapped to that ID and invalidates the entry. If the ID is unmapped, or the key without bit 28 is 32 or more, nothing changes.
- R10: When a release and a request are accepted in the same cycle, the release takes effect first, so the request may be granted the channel just freed.
- R11: A lookup of an unmapped ID returns `lkp_valid`=0 and `lkp_chan`=0.
- R12: `rsp_valid` is 1 in exactly the cycle after an accepted request and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Allocator accepts requests |
| req_id | input | 5 | Logical peripheral ID of the request |
| rel_valid | input | 1 | Release present |
| rel_ready | output | 1 | Allocator accepts releases |
| rel_key | input | 32 | Handle (bit 28 set) or logical ID to release |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_busy | output | 1 | Request failed, bank full |
| rsp_handle | output | 32 | Granted handle, 0 on failure |
| lkp_id | input | 5 | Logical ID to look up |
| lkp_valid | output | 1 | Looked-up ID has a mapped channel |
| lkp_chan | output | 4 | Mapped channel of the looked-up ID |
| own_chan | input | 4 | Physical channel to inspect |
| own_busy | output | 1 | Inspected channel is busy |
| own_id | output | 5 | Owner ID of the inspected channel |

## Verification
The assertions assume that reset is held for at least one clock before operation and that inputs are stable around the sampling edge. They also assume that when a request and a release on the same channel coincide, the release-first order holds. Each checks one-cycle relations only: a granted channel was free and becomes busy, a refused request leaves occupancy unchanged, and a cleared map entry stays cleared unless re-granted in the same cycle. The stimulus changes inputs only on the falling edge, holds each operation for exactly one rising edge, and keeps every ID inside the 5-bit range. It also crafts release keys both well-formed and malformed, so the decode paths are reached without ever presenting an undefined value.

// File: rtl/dmaalloc_pkg.sv
package dmaalloc_pkg;
  localparam int DEF_BANKS    = 2;
  localparam int DEF_BANK_CH  = 8;
  localparam int DEF_IDS      = 32;
  localparam int DEF_SPLIT    = 16;
  localparam int DEF_KEY_W    = 32;
  localparam int DEF_FLAG_BIT = 28;

  typedef enum logic [1:0] {
    REL_NONE      = 2'd0,
    REL_BY_ID     = 2'd1,
    REL_BY_HANDLE = 2'd2
  } rel_kind_e;
endpackage

// File: rtl/dmaalloc_pick.sv
module dmaalloc_pick #(
  parameter int BANKS   = 2,
  parameter int BANK_CH = 8,
  localparam int CH_N   = BANKS * BANK_CH,
  localparam int CH_W   = $clog2(CH_N),
  localparam int BW     = $clog2(BANK_CH),
  localparam int BKW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_N-1:0] occ,
  input  logic [BKW-1:0]  bank,
  output logic            found,
  output logic [CH_W-1:0] pick
);
  logic [BANKS-1:0]    hit_v;
  logic [BANKS*BW-1:0] idx_v;
  logic [BW-1:0]       idx_sel;

  // first-free scan, one per bank
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BANK_CH-1:0] slice;
    logic               hit;
    logic [BW-1:0]      idx;
    assign slice = occ[b*BANK_CH +: BANK_CH];
    always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = BANK_CH - 1; i >= 0; i--) begin
        if (!slice[i]) begin
          hit = 1'b1;
          idx = BW'(i);
        end
      end
    end
    assign hit_v[b]           = hit;
    assign idx_v[b*BW +: BW]  = idx;
  end

  assign found   = hit_v[bank];
  assign idx_sel = idx_v[int'(bank)*BW +: BW];
  assign pick    = CH_W'(int'(bank) * BANK_CH + int'(idx_sel));

  // independent view of the selected bank for the checks
  logic [BANK_CH-1:0] bank_occ;
  logic               lower_free;
  logic               bank_full;
  assign bank_occ = occ[int'(bank)*BANK_CH +: BANK_CH];
  always_comb begin
    lower_free = 1'b0;
    bank_full  = 1'b1;
    for (int i = 0; i < BANK_CH; i++) begin
      if (!bank_occ[i]) begin
        bank_full = 1'b0;
        if (i < int'(idx_sel)) lower_free = 1'b1;
      end
    end
  end

  // R3
  pick_was_free_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> !occ[pick]);
  // R3
  pick_is_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> !lower_free);
  // R4
  miss_means_full_chk: assert property (@(posedge clk) disable iff (rst)
    !found |-> bank_full);
endmodule

// File: rtl/dmaalloc_occ.sv
module dmaalloc_occ #(
  parameter int CH_N = 16,
  parameter int ID_W = 5,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rel_en,
  input  logic [CH_W-1:0] rel_ch,
  input  logic            grant_en,
  input  logic [CH_W-1:0] grant_ch,
  input  logic [ID_W-1:0] grant_id,
  input  logic [CH_W-1:0] qry_ch,
  output logic [CH_N-1:0] occ_eff,
  output logic            qry_busy,
  output logic [ID_W-1:0] qry_id
);
  logic [CH_N-1:0] used_q;
  logic [CH_N-1:0] set_mask;
  logic [ID_W-1:0] owner_q [CH_N];

  // release is applied before the grant sees the vector
  always_comb begin
    occ_eff = used_q;
    if (rel_en) occ_eff[rel_ch] = 1'b0;
  end

  assign set_mask = grant_en ? (CH_N'(1) << grant_ch) : '0;

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else     used_q <= occ_eff | set_mask;
  end

  // owner table: plain write port, no reset
  always_ff @(posedge clk) begin
    if (grant_en) owner_q[grant_ch] <= grant_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_busy <= 1'b0;
      qry_id   <= '0;
    end else begin
      qry_busy <= used_q[qry_ch];
      qry_id   <= used_q[qry_ch] ? owner_q[qry_ch] : '0;
    end
  end

  // R4
  idle_keeps_occ_chk: assert property (@(posedge clk) disable iff (rst)
    !grant_en |=> used_q == $past(occ_eff));
  // R6
  grant_marks_busy_chk: assert property (@(posedge clk) disable iff (rst)
    grant_en |=> used_q[$past(grant_ch)]);
  // R8
  release_frees_chk: assert property (@(posedge clk) disable iff (rst)
    rel_en && !(grant_en && grant_ch == rel_ch) |=> !used_q[$past(rel_ch)]);
endmodule

// File: rtl/dmaalloc_map.sv
module dmaalloc_map #(
  parameter int IDS  = 32,
  parameter int CH_W = 4,
  localparam int ID_W = $clog2(IDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] rd_id,
  output logic            rd_vld,
  output logic [CH_W-1:0] rd_ch,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic [CH_W-1:0] set_ch,
  input  logic [ID_W-1:0] lk_id,
  output logic            lk_vld,
  output logic [CH_W-1:0] lk_ch
);
  logic [IDS-1:0]  vld_q;
  logic [IDS-1:0]  vld_d;
  logic [CH_W-1:0] chan_mem [IDS];

  assign rd_vld = vld_q[rd_id];
  assign rd_ch  = chan_mem[rd_id];

  always_comb begin
    vld_d = vld_q;
    if (clr_en) vld_d[clr_id] = 1'b0;
    if (set_en) vld_d[set_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (set_en) chan_mem[set_id] <= set_ch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vld <= 1'b0;
      lk_ch  <= '0;
    end else begin
      lk_vld <= vld_q[lk_id];
      lk_ch  <= vld_q[lk_id] ? chan_mem[lk_id] : '0;
    end
  end

  // R7
  set_marks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> vld_q[$past(set_id)]);
  // R9
  clear_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en && !(set_en && set_id == clr_id) |=> !vld_q[$past(clr_id)]);
endmodule

// File: rtl/dma_chan_alloc.sv
module dma_chan_alloc
  import dmaalloc_pkg::*;
#(
  parameter int BANKS    = DEF_BANKS,
  parameter int BANK_CH  = DEF_BANK_CH,
  parameter int IDS      = DEF_IDS,
  parameter int SPLIT    = DEF_SPLIT,
  parameter int KEY_W    = DEF_KEY_W,
  parameter int FLAG_BIT = DEF_FLAG_BIT,
  localparam int CH_N    = BANKS * BANK_CH,
  localparam int CH_W    = $clog2(CH_N),
  localparam int ID_W    = $clog2(IDS),
  localparam int BKW     = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int SPL_W   = $clog2(SPLIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_id,
  input  logic             rel_valid,
  output logic             rel_ready,
  input  logic [KEY_W-1:0] rel_key,
  output logic             rsp_valid,
  output logic             rsp_busy,
  output logic [KEY_W-1:0] rsp_handle,
  input  logic [ID_W-1:0]  lkp_id,
  output logic             lkp_valid,
  output logic [CH_W-1:0]  lkp_chan,
  input  logic [CH_W-1:0]  own_chan,
  output logic             own_busy,
  output logic [ID_W-1:0]  own_id
);
  logic ready_q;
  logic req_fire, rel_fire;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign req_ready = ready_q;
  assign rel_ready = ready_q;
  assign req_fire  = req_valid & ready_q;
  assign rel_fire  = rel_valid & ready_q;

  // release key decode
  logic [KEY_W-1:0] key_noflag;
  logic             key_is_handle, key_is_id;
  rel_kind_e        rel_kind;
  logic             map_rd_vld;
  logic [CH_W-1:0]  map_rd_ch;
  logic             rel_en;
  logic [CH_W-1:0]  rel_ch;
  logic             clr_en;

  always_comb begin
    key_noflag           = rel_key;
    key_noflag[FLAG_BIT] = 1'b0;
  end
  assign key_is_handle = rel_key[FLAG_BIT] && ((key_noflag >> CH_W) == '0);
  assign key_is_id     = !rel_key[FLAG_BIT] && ((rel_key >> ID_W) == '0);

  always_comb begin
    rel_kind = REL_NONE;
    if (rel_fire) begin
      if (key_is_handle)  rel_kind = REL_BY_HANDLE;
      else if (key_is_id) rel_kind = REL_BY_ID;
    end
  end

  assign rel_en = (rel_kind == REL_BY_HANDLE) || (rel_kind == REL_BY_ID && map_rd_vld);
  assign rel_ch = (rel_kind == REL_BY_HANDLE) ? rel_key[CH_W-1:0] : map_rd_ch;
  assign clr_en = (rel_kind == REL_BY_ID);

  // bank selection from the logical ID range
  logic [ID_W-1:0] id_bank;
  logic [BKW-1:0]  bank_sel;
  assign id_bank  = req_id >> SPL_W;
  assign bank_sel = (int'(id_bank) >= BANKS) ? BKW'(BANKS - 1) : id_bank[BKW-1:0];

  logic [CH_N-1:0] occ_eff;
  logic            found;
  logic [CH_W-1:0] pick;
  logic            grant_en;
  assign grant_en = req_fire & found;

  dmaalloc_pick #(.BANKS(BANKS), .BANK_CH(BANK_CH)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .occ   (occ_eff),
    .bank  (bank_sel),
    .found (found),
    .pick  (pick)
  );

  dmaalloc_occ #(.CH_N(CH_N), .ID_W(ID_W)) u_occ (
    .clk      (clk),
    .rst      (rst),
    .rel_en   (rel_en),
    .rel_ch   (rel_ch),
    .grant_en (grant_en),
    .grant_ch (pick),
    .grant_id (req_id),
    .qry_ch   (own_chan),
    .occ_eff  (occ_eff),
    .qry_busy (own_busy),
    .qry_id   (own_id)
  );

  dmaalloc_map #(.IDS(IDS), .CH_W(CH_W)) u_map (
    .clk    (clk),
    .rst    (rst),
    .rd_id  (rel_key[ID_W-1:0]),
    .rd_vld (map_rd_vld),
    .rd_ch  (map_rd_ch),
    .clr_en (clr_en),
    .clr_id (rel_key[ID_W-1:0]),
    .set_en (grant_en),
    .set_id (req_id),
    .set_ch (pick),
    .lk_id  (lkp_id),
    .lk_vld (lkp_valid),
    .lk_ch  (lkp_chan)
  );

  // registered response
  logic [KEY_W-1:0] handle_d;
  always_comb begin
    handle_d = '0;
    if (grant_en) begin
      handle_d[FLAG_BIT]   = 1'b1;
      handle_d[CH_W-1:0]   = pick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_busy   <= 1'b0;
      rsp_handle <= '0;
    end else begin
      rsp_valid  <= req_fire;
      rsp_busy   <= req_fire & ~found;
      rsp_handle <= handle_d;
    end
  end

  // R12
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> rsp_valid);
  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_fire |=> !rsp_valid);
  // R5
  handle_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_busy |-> rsp_handle[FLAG_BIT] && ((key_noflag_of(rsp_handle) >> CH_W) == '0));
  // R4
  busy_handle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_busy |-> rsp_handle == '0);
  // R2
  bank_match_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_busy |-> (int'(rsp_handle[CH_W-1:0]) / BANK_CH) == int'($past(bank_sel)));

  function automatic logic [KEY_W-1:0] key_noflag_of(input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] r;
    r = k;
    r[FLAG_BIT] = 1'b0;
    return r;
  endfunction
endmodule

// File: tb/sim_dma_chan_alloc.sv
module sim_dma_chan_alloc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_id = '0;
  logic        rel_valid = 1'b0;
  logic        rel_ready;
  logic [31:0] rel_key = '0;
  logic        rsp_valid, rsp_busy;
  logic [31:0] rsp_handle;
  logic [4:0]  lkp_id = '0;
  logic        lkp_valid;
  logic [3:0]  lkp_chan;
  logic [3:0]  own_chan = '0;
  logic        own_busy;
  logic [4:0]  own_id;

  int n_chk = 0;
  int n_err = 0;

  localparam logic [31:0] HFLAG = 32'h1000_0000;

  always #2.5ns clk = ~clk;

  dma_chan_alloc u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_key(rel_key),
    .rsp_valid(rsp_valid), .rsp_busy(rsp_busy), .rsp_handle(rsp_handle),
    .lkp_id(lkp_id), .lkp_valid(lkp_valid), .lkp_chan(lkp_chan),
    .own_chan(own_chan), .own_busy(own_busy), .own_id(own_id)
  );

  typedef struct packed {
    logic [1:0] op;    // 0 request, 1 release by ID, 2 release by handle
    logic [4:0] arg;
    logic       busy;
    logic [3:0] ch;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{2'd0, 5'd3,  1'b0, 4'd0},
    '{2'd0, 5'd5,  1'b0, 4'd1},
    '{2'd0, 5'd20, 1'b0, 4'd8},
    '{2'd0, 5'd0,  1'b0, 4'd2},
    '{2'd2, 5'd1,  1'b0, 4'd0},
    '{2'd0, 5'd7,  1'b0, 4'd1},
    '{2'd1, 5'd3,  1'b0, 4'd0},
    '{2'd0, 5'd17, 1'b0, 4'd9},
    '{2'd0, 5'd9,  1'b0, 4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [4:0] id);
    @(negedge clk);
    req_valid = 1'b1;
    req_id    = id;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_rel(input logic [31:0] key);
    @(negedge clk);
    rel_valid = 1'b1;
    rel_key   = key;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic look(input logic [4:0] id);
    @(negedge clk);
    lkp_id = id;
    @(negedge clk);
  endtask

  task automatic owner(input logic [3:0] ch);
    @(negedge clk);
    own_chan = ch;
    @(negedge clk);
  endtask

  task automatic expect_grant(input string tag, input logic [3:0] ch);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " busy"}, 32'(rsp_busy), 32'd0);
    chk({tag, " handle"}, rsp_handle, HFLAG | 32'(ch));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rel_ready", 32'(rel_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    look(5'd3);
    chk("R1 map empty", 32'(lkp_valid), 32'd0);
    owner(4'd0);
    chk("R1 ch0 free", 32'(own_busy), 32'd0);
    owner(4'd12);
    chk("R1 ch12 free", 32'(own_busy), 32'd0);

    // table walk: R2 R3 R5 R8 R9 R12
    for (int k = 0; k <= 8; k++) begin
      case (VEC[k].op)
        2'd0: begin
          do_req(VEC[k].arg);
          expect_grant($sformatf("R3 vec%0d", k), VEC[k].ch);
        end
        2'd1: begin
          do_rel(32'(VEC[k].arg));
          chk($sformatf("R12 vec%0d no rsp", k), 32'(rsp_valid), 32'd0);
        end
        default: begin
          do_rel(HFLAG | 32'(VEC[k].arg));
          chk($sformatf("R12 vec%0d no rsp", k), 32'(rsp_valid), 32'd0);
        end
      endcase
    end

    // R2 fill bank 0
    for (int k = 0; k < 5; k++) begin
      do_req(5'(10 + k));
      expect_grant("R2 fill", 4'(3 + k));
    end
    // R4 full bank
    do_req(5'd15);
    chk("R4 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R4 busy", 32'(rsp_busy), 32'd1);
    chk("R4 handle", rsp_handle, 32'd0);
    look(5'd15);
    chk("R4 map untouched", 32'(lkp_valid), 32'd0);
    owner(4'd7);
    chk("R4 owner kept", 32'(own_id), 32'd14);
    do_req(5'd16);
    expect_grant("R2 bank1", 4'd10);

    // R8 handle release left the stale map entry
    look(5'd5);
    chk("R8 stale valid", 32'(lkp_valid), 32'd1);
    chk("R8 stale chan", 32'(lkp_chan), 32'd1);
    // R6 owner of reused channel
    owner(4'd1);
    chk("R6 busy", 32'(own_busy), 32'd1);
    chk("R6 id", 32'(own_id), 32'd7);
    // R7 map entries
    look(5'd20);
    chk("R7 id20", {27'd0, lkp_valid, lkp_chan}, {27'd0, 1'b1, 4'd8});
    look(5'd17);
    chk("R7 id17", {27'd0, lkp_valid, lkp_chan}, {27'd0, 1'b1, 4'd9});
    // R11 cleared entry
    look(5'd3);
    chk("R11 valid", 32'(lkp_valid), 32'd0);
    chk("R11 chan", 32'(lkp_chan), 32'd0);

    // R10 same-cycle release and request
    @(negedge clk);
    rel_valid = 1'b1; rel_key = HFLAG | 32'd4;
    req_valid = 1'b1; req_id = 5'd15;
    @(negedge clk);
    rel_valid = 1'b0; req_valid = 1'b0;
    expect_grant("R10 reuse", 4'd4);

    // R9 unmapped and out-of-range releases change nothing
    do_rel(32'd3);
    do_rel(32'd64);
    owner(4'd0);
    chk("R9 ch0 still busy", 32'(own_busy), 32'd1);
    chk("R9 ch0 owner", 32'(own_id), 32'd9);
    // R8 malformed handle ignored
    do_rel(HFLAG | 32'h100 | 32'd8);
    owner(4'd8);
    chk("R8 malformed ignored", 32'(own_busy), 32'd1);
    // R9 release by ID
    do_rel(32'd9);
    owner(4'd0);
    chk("R9 ch0 freed", 32'(own_busy), 32'd0);
    look(5'd9);
    chk("R9 entry cleared", 32'(lkp_valid), 32'd0);
    do_req(5'd31);
    expect_grant("R3 bank1 next", 4'd11);
    do_req(5'd2);
    expect_grant("R3 reuse ch0", 4'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule